// File: doc/BRIEF.md
# Framebuffer Mode Geometry Validator

This block sits between the software-written display control registers and the scan-out engine. It takes the raw register values (enable, colour depth, visible resolution, virtual line width, pan offsets, framebuffer byte order) and the size of the attached video memory. From them it derives a complete display mode: the pixel format code, bytes per pixel, line stride, frame size and panned start offset. It then decides whether that mode can be shown at all.

The derived mode is latched only on a periodic update tick, so the scan-out side sees a stable geometry between ticks. A rejected mode never reaches the latch: the last good geometry stays in place and only the valid flag drops. When a tick accepts a mode that differs in any field from the one held, a one-cycle change strobe tells the consumer to rebuild its surface and redraw the whole frame.

Top module: `fb_mode_check`

## Requirements
- R1: When `enable_i` is low at an update tick, the tick leaves `valid_o` low, keeps every latched mode field and raises no strobe.
- R2: Only a depth of 16 gives a valid mode with 2 bytes per pixel and format code 1 (5-6-5), and only a depth of 32 gives 4 bytes per pixel. Any other depth value is rejected.
- R3: At depth 32 the format code is 3 when `big_endian_i` is high and 2 when it is low. Depth 16 gives code 1 whatever the byte-order input is.
- R4: The line stride is the larger of `vwidth_i` and `xres_i`, multiplied by the bytes per pixel.
- R5: The frame size is stride times `yres_i`, and the start offset is `xoff_i` times bytes per pixel plus `yoff_i` times stride. Both are computed wide enough that no product or sum is truncated.
- R6: A mode whose `xres_i` or `yres_i` is below 64 is rejected.
- R7: A mode is rejected when offset plus size is greater than `mem_bytes_i`. A mode that ends exactly at the memory size is accepted.
- R8: Outputs change only on the clock edge where `tick_i` is high, and show the result from the following cycle on. Without a tick, register changes have no effect on any output.
- R9: `changed_o` is high for exactly the cycle after a tick that accepts a mode differing from the latched one. It stays low when the accepted mode equals the latched one.
- R10: After reset every mode output is zero (format code 0), and `valid_o` and `changed_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Update tick; the mode is evaluated and latched on this edge |
| enable_i | input | 1 | Display enable register bit |
| bpp_i | input | REG_W | Colour depth register, in bits per pixel |
| big_endian_i | input | 1 | Framebuffer byte order, 1 = big endian |
| xres_i | input | REG_W | Visible width, in pixels |
| yres_i | input | REG_W | Visible height, in lines |
| vwidth_i | input | REG_W | Virtual line width, in pixels |
| xoff_i | input | REG_W | Horizontal pan, in pixels |
| yoff_i | input | REG_W | Vertical pan, in lines |
| mem_bytes_i | input | MEM_W | Video memory size, in bytes |
| fmt_o | output | 2 | Format: 0 none, 1 5-6-5, 2 x8r8g8b8 little endian, 3 x8r8g8b8 big endian |
| bytes_o | output | 3 | Bytes per pixel |
| width_o | output | REG_W | Latched visible width |
| height_o | output | REG_W | Latched visible height |
| stride_o | output | REG_W+3 | Latched line stride, in bytes |
| offset_o | output | 2*REG_W+4 | Latched start offset, in bytes |
| size_o | output | 2*REG_W+3 | Latched frame size, in bytes |
| valid_o | output | 1 | The mode evaluated at the last tick was accepted |
| changed_o | output | 1 | One-cycle strobe: a new and different mode was latched |

## Verification
The memory-fit property compares the latched geometry with the live `mem_bytes_i`. It therefore assumes that the memory size is a static configuration value that does not move while a mode is valid. The bench sets it once before reset is released and never touches it again. Other assertions assume that the tick and the register inputs are synchronous to the clock. The bench changes them only on falling edges, always asserts the tick for exactly one cycle, and leaves idle cycles between ticks so that every strobe can be seen on its own.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  typedef enum logic [1:0] {
    FMT_NONE    = 2'd0,
    FMT_RGB565  = 2'd1,
    FMT_XRGB_LE = 2'd2,
    FMT_XRGB_BE = 2'd3
  } pix_fmt_e;

  localparam int unsigned DEPTH_LO = 16;
  localparam int unsigned DEPTH_HI = 32;
endpackage

// File: rtl/fbm_format_decode.sv
module fbm_format_decode #(
  parameter int unsigned REG_W = 16
) (
  input  logic [REG_W-1:0] bpp_i,
  input  logic             big_endian_i,
  output logic [1:0]       fmt_o,
  output logic [2:0]       bytes_o,
  output logic             ok_o
);
  import fbm_pkg::*;

  pix_fmt_e fmt;

  always_comb begin
    fmt     = FMT_NONE;
    bytes_o = 3'd0;
    ok_o    = 1'b0;
    if (bpp_i == REG_W'(DEPTH_LO)) begin
      fmt     = FMT_RGB565;
      bytes_o = 3'd2;
      ok_o    = 1'b1;
    end else if (bpp_i == REG_W'(DEPTH_HI)) begin
      fmt     = big_endian_i ? FMT_XRGB_BE : FMT_XRGB_LE;
      bytes_o = 3'd4;
      ok_o    = 1'b1;
    end
  end

  assign fmt_o = fmt;
endmodule

// File: rtl/fbm_geometry.sv
module fbm_geometry #(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned STRIDE_W = REG_W + 3,
  parameter int unsigned SIZE_W   = STRIDE_W + REG_W,
  parameter int unsigned OFS_W    = SIZE_W + 1
) (
  input  logic [2:0]          bytes_i,
  input  logic [REG_W-1:0]    xres_i,
  input  logic [REG_W-1:0]    yres_i,
  input  logic [REG_W-1:0]    vwidth_i,
  input  logic [REG_W-1:0]    xoff_i,
  input  logic [REG_W-1:0]    yoff_i,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [SIZE_W-1:0]   size_o,
  output logic [OFS_W-1:0]    offset_o
);
  logic [REG_W-1:0] eff_w;
  logic [OFS_W-1:0] pan_x;
  logic [OFS_W-1:0] pan_y;

  // a virtual width narrower than the screen is widened to it
  assign eff_w    = (vwidth_i < xres_i) ? xres_i : vwidth_i;
  assign stride_o = STRIDE_W'(eff_w) * STRIDE_W'(bytes_i);
  assign size_o   = SIZE_W'(stride_o) * SIZE_W'(yres_i);
  assign pan_x    = OFS_W'(xoff_i) * OFS_W'(bytes_i);
  assign pan_y    = OFS_W'(yoff_i) * OFS_W'(stride_o);
  assign offset_o = pan_x + pan_y;
endmodule

// File: rtl/fbm_fit_check.sv
module fbm_fit_check #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned MEM_W   = 32,
  parameter int unsigned MIN_DIM = 64,
  parameter int unsigned SIZE_W  = 2 * REG_W + 3,
  parameter int unsigned OFS_W   = SIZE_W + 1
) (
  input  logic [REG_W-1:0]  xres_i,
  input  logic [REG_W-1:0]  yres_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [MEM_W-1:0]  mem_bytes_i,
  output logic              ok_o
);
  localparam int unsigned END_W = (OFS_W + 1 > MEM_W) ? OFS_W + 1 : MEM_W;

  logic [END_W-1:0] end_addr;
  logic             dims_ok;
  logic             fits;

  assign end_addr = END_W'(offset_i) + END_W'(size_i);
  assign dims_ok  = (xres_i >= REG_W'(MIN_DIM)) && (yres_i >= REG_W'(MIN_DIM));
  assign fits     = end_addr <= END_W'(mem_bytes_i);
  assign ok_o     = dims_ok && fits;
endmodule

// File: rtl/fbm_mode_latch.sv
module fbm_mode_latch #(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned STRIDE_W = REG_W + 3,
  parameter int unsigned SIZE_W   = STRIDE_W + REG_W,
  parameter int unsigned OFS_W    = SIZE_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                ok_i,
  input  logic [1:0]          fmt_i,
  input  logic [2:0]          bytes_i,
  input  logic [REG_W-1:0]    width_i,
  input  logic [REG_W-1:0]    height_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [OFS_W-1:0]    offset_i,
  input  logic [SIZE_W-1:0]   size_i,
  output logic [1:0]          fmt_o,
  output logic [2:0]          bytes_o,
  output logic [REG_W-1:0]    width_o,
  output logic [REG_W-1:0]    height_o,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [OFS_W-1:0]    offset_o,
  output logic [SIZE_W-1:0]   size_o,
  output logic                valid_o,
  output logic                changed_o
);
  logic differ;

  assign differ = (fmt_i != fmt_o) || (bytes_i != bytes_o) ||
                  (width_i != width_o) || (height_i != height_o) ||
                  (stride_i != stride_o) || (offset_i != offset_o) ||
                  (size_i != size_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_o     <= '0;
      bytes_o   <= '0;
      width_o   <= '0;
      height_o  <= '0;
      stride_o  <= '0;
      offset_o  <= '0;
      size_o    <= '0;
      valid_o   <= 1'b0;
      changed_o <= 1'b0;
    end else if (tick_i) begin
      valid_o   <= ok_i;
      changed_o <= ok_i && differ;
      if (ok_i) begin
        fmt_o    <= fmt_i;
        bytes_o  <= bytes_i;
        width_o  <= width_i;
        height_o <= height_i;
        stride_o <= stride_i;
        offset_o <= offset_i;
        size_o   <= size_i;
      end
    end else begin
      changed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fb_mode_check.sv
module fb_mode_check #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned MEM_W   = 32,
  parameter int unsigned MIN_DIM = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 enable_i,
  input  logic [REG_W-1:0]     bpp_i,
  input  logic                 big_endian_i,
  input  logic [REG_W-1:0]     xres_i,
  input  logic [REG_W-1:0]     yres_i,
  input  logic [REG_W-1:0]     vwidth_i,
  input  logic [REG_W-1:0]     xoff_i,
  input  logic [REG_W-1:0]     yoff_i,
  input  logic [MEM_W-1:0]     mem_bytes_i,
  output logic [1:0]           fmt_o,
  output logic [2:0]           bytes_o,
  output logic [REG_W-1:0]     width_o,
  output logic [REG_W-1:0]     height_o,
  output logic [REG_W+2:0]     stride_o,
  output logic [2*REG_W+3:0]   offset_o,
  output logic [2*REG_W+2:0]   size_o,
  output logic                 valid_o,
  output logic                 changed_o
);
  localparam int unsigned STRIDE_W = REG_W + 3;
  localparam int unsigned SIZE_W   = STRIDE_W + REG_W;
  localparam int unsigned OFS_W    = SIZE_W + 1;

  logic [1:0]          c_fmt;
  logic [2:0]          c_bytes;
  logic                fmt_ok;
  logic [STRIDE_W-1:0] c_stride;
  logic [SIZE_W-1:0]   c_size;
  logic [OFS_W-1:0]    c_offset;
  logic                fit_ok;
  logic                cand_ok;

  fbm_format_decode #(.REG_W(REG_W)) u_fmt (
    .bpp_i       (bpp_i),
    .big_endian_i(big_endian_i),
    .fmt_o       (c_fmt),
    .bytes_o     (c_bytes),
    .ok_o        (fmt_ok)
  );

  fbm_geometry #(
    .REG_W(REG_W), .STRIDE_W(STRIDE_W), .SIZE_W(SIZE_W), .OFS_W(OFS_W)
  ) u_geom (
    .bytes_i (c_bytes),
    .xres_i  (xres_i),
    .yres_i  (yres_i),
    .vwidth_i(vwidth_i),
    .xoff_i  (xoff_i),
    .yoff_i  (yoff_i),
    .stride_o(c_stride),
    .size_o  (c_size),
    .offset_o(c_offset)
  );

  fbm_fit_check #(
    .REG_W(REG_W), .MEM_W(MEM_W), .MIN_DIM(MIN_DIM), .SIZE_W(SIZE_W), .OFS_W(OFS_W)
  ) u_fit (
    .xres_i     (xres_i),
    .yres_i     (yres_i),
    .size_i     (c_size),
    .offset_i   (c_offset),
    .mem_bytes_i(mem_bytes_i),
    .ok_o       (fit_ok)
  );

  assign cand_ok = enable_i && fmt_ok && fit_ok;

  fbm_mode_latch #(
    .REG_W(REG_W), .STRIDE_W(STRIDE_W), .SIZE_W(SIZE_W), .OFS_W(OFS_W)
  ) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ok_i     (cand_ok),
    .fmt_i    (c_fmt),
    .bytes_i  (c_bytes),
    .width_i  (xres_i),
    .height_i (yres_i),
    .stride_i (c_stride),
    .offset_i (c_offset),
    .size_i   (c_size),
    .fmt_o    (fmt_o),
    .bytes_o  (bytes_o),
    .width_o  (width_o),
    .height_o (height_o),
    .stride_o (stride_o),
    .offset_o (offset_o),
    .size_o   (size_o),
    .valid_o  (valid_o),
    .changed_o(changed_o)
  );
endmodule

// File: rtl/fbm_mode_checker.sv
module fbm_mode_checker #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned MEM_W   = 32,
  parameter int unsigned MIN_DIM = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               enable_i,
  input logic [REG_W-1:0]   xres_i,
  input logic [REG_W-1:0]   yres_i,
  input logic [MEM_W-1:0]   mem_bytes_i,
  input logic [1:0]         fmt_o,
  input logic [2:0]         bytes_o,
  input logic [REG_W-1:0]   width_o,
  input logic [REG_W-1:0]   height_o,
  input logic [REG_W+2:0]   stride_o,
  input logic [2*REG_W+3:0] offset_o,
  input logic [2*REG_W+2:0] size_o,
  input logic               valid_o,
  input logic               changed_o
);
  localparam int unsigned STRIDE_W = REG_W + 3;
  localparam int unsigned OFS_W    = 2 * REG_W + 4;
  localparam int unsigned END_W    = (OFS_W + 1 > MEM_W) ? OFS_W + 1 : MEM_W;

  logic [STRIDE_W-1:0] min_stride;
  logic [END_W-1:0]    frame_end;
  logic                small_dim;

  assign min_stride = STRIDE_W'(width_o) * STRIDE_W'(bytes_o);
  assign frame_end  = END_W'(offset_o) + END_W'(size_o);
  assign small_dim  = (xres_i < REG_W'(MIN_DIM)) || (yres_i < REG_W'(MIN_DIM));

  assert_disabled_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !enable_i) |=> (!valid_o && !changed_o));

  assert_depth_bytes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((bytes_o == 3'd2 && fmt_o == 2'd1) || (bytes_o == 3'd4 && fmt_o[1])));

  assert_stride_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (stride_o >= min_stride));

  assert_small_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && small_dim) |=> !valid_o);

  assert_fits_memory_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (frame_end <= END_W'(mem_bytes_i)));

  assert_hold_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(fmt_o) && $stable(stride_o) && $stable(offset_o) &&
                 $stable(size_o) && $stable(width_o) && $stable(height_o) &&
                 $stable(valid_o) && !changed_o));

  assert_strobe_after_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_o |-> ($past(tick_i) && valid_o));
endmodule

bind fb_mode_check fbm_mode_checker #(
  .REG_W(REG_W), .MEM_W(MEM_W), .MIN_DIM(MIN_DIM)
) u_fbm_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .enable_i   (enable_i),
  .xres_i     (xres_i),
  .yres_i     (yres_i),
  .mem_bytes_i(mem_bytes_i),
  .fmt_o      (fmt_o),
  .bytes_o    (bytes_o),
  .width_o    (width_o),
  .height_o   (height_o),
  .stride_o   (stride_o),
  .offset_o   (offset_o),
  .size_o     (size_o),
  .valid_o    (valid_o),
  .changed_o  (changed_o)
);

// File: tb/fb_mode_check_bench.sv
module fb_mode_check_bench;
  localparam int unsigned REG_W = 16;
  localparam int unsigned MEM_W = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               tick = 1'b0;
  logic               en = 1'b0;
  logic [REG_W-1:0]   bpp = '0;
  logic               be = 1'b0;
  logic [REG_W-1:0]   xres = '0, yres = '0, vw = '0, xoff = '0, yoff = '0;
  logic [MEM_W-1:0]   mem = 32'd4194304;
  logic [1:0]         fmt;
  logic [2:0]         bytes_pp;
  logic [REG_W-1:0]   width, height;
  logic [REG_W+2:0]   stride;
  logic [2*REG_W+3:0] offset;
  logic [2*REG_W+2:0] size;
  logic               valid, changed;

  int    n_run = 0, n_fail = 0, cycles = 0;
  bit    done = 0;
  string cur_req = "R10";

  // reference model state
  longint m_fmt, m_bytes, m_w, m_h, m_stride, m_ofs, m_size;
  bit     m_valid, m_chg;

  fb_mode_check u_fb_mode_check (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .enable_i(en), .bpp_i(bpp),
    .big_endian_i(be), .xres_i(xres), .yres_i(yres), .vwidth_i(vw),
    .xoff_i(xoff), .yoff_i(yoff), .mem_bytes_i(mem), .fmt_o(fmt),
    .bytes_o(bytes_pp), .width_o(width), .height_o(height), .stride_o(stride),
    .offset_o(offset), .size_o(size), .valid_o(valid), .changed_o(changed)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fmt = 0; m_bytes = 0; m_w = 0; m_h = 0; m_stride = 0; m_ofs = 0;
      m_size = 0; m_valid = 0; m_chg = 0;
    end else if (tick) begin
      longint b, f, ew, st, sz, of;
      bit ok;
      b  = (bpp == 16) ? 2 : (bpp == 32) ? 4 : 0;
      f  = (bpp == 16) ? 1 : (be ? 3 : 2);
      ew = (longint'(vw) > longint'(xres)) ? longint'(vw) : longint'(xres);
      st = ew * b;
      sz = st * longint'(yres);
      of = longint'(xoff) * b + longint'(yoff) * st;
      ok = en && (b != 0) && (xres >= 64) && (yres >= 64) && (of + sz <= longint'(mem));
      m_valid = ok;
      m_chg   = 0;
      if (ok) begin
        m_chg = (f != m_fmt) || (b != m_bytes) || (longint'(xres) != m_w) ||
                (longint'(yres) != m_h) || (st != m_stride) || (of != m_ofs) || (sz != m_size);
        m_fmt = f; m_bytes = b; m_w = longint'(xres); m_h = longint'(yres);
        m_stride = st; m_ofs = of; m_size = sz;
      end
    end else begin
      m_chg = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "model fmt", longint'(fmt), m_fmt);
      chk(cur_req, "model bytes", longint'(bytes_pp), m_bytes);
      chk(cur_req, "model width", longint'(width), m_w);
      chk(cur_req, "model height", longint'(height), m_h);
      chk(cur_req, "model stride", longint'(stride), m_stride);
      chk(cur_req, "model offset", longint'(offset), m_ofs);
      chk(cur_req, "model size", longint'(size), m_size);
      chk(cur_req, "model valid", longint'(valid), longint'(m_valid));
      chk(cur_req, "model strobe", longint'(changed), longint'(m_chg));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic set_mode(bit e, int d, bit b, int x, int y, int v, int ox, int oy);
    en = e; bpp = REG_W'(d); be = b; xres = REG_W'(x); yres = REG_W'(y);
    vw = REG_W'(v); xoff = REG_W'(ox); yoff = REG_W'(oy);
  endtask

  // tick for one cycle; returns at the negedge where the result is visible
  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R10";
    chk("R10", "reset fmt", longint'(fmt), 0);
    chk("R10", "reset valid", longint'(valid), 0);
    chk("R10", "reset strobe", longint'(changed), 0);
    chk("R10", "reset size", longint'(size), 0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R9";
    set_mode(1, 32, 0, 640, 480, 0, 0, 0);
    do_tick();
    chk("R9", "first mode strobe", longint'(changed), 1);
    chk("R3", "le fmt", longint'(fmt), 2);
    chk("R4", "stride 640x4", longint'(stride), 2560);
    chk("R5", "size", longint'(size), 1228800);
    idle(1);
    chk("R9", "strobe one cycle", longint'(changed), 0);
    do_tick();
    chk("R9", "same mode no strobe", longint'(changed), 0);
    idle(2);

    cur_req = "R3";
    be = 1'b1;
    do_tick();
    chk("R3", "be fmt", longint'(fmt), 3);
    chk("R9", "byte order strobe", longint'(changed), 1);
    idle(2);

    cur_req = "R2";
    bpp = 16;
    do_tick();
    chk("R2", "16bpp bytes", longint'(bytes_pp), 2);
    chk("R3", "16bpp native fmt", longint'(fmt), 1);
    chk("R4", "16bpp stride", longint'(stride), 1280);
    idle(2);

    cur_req = "R4";
    set_mode(1, 32, 0, 640, 480, 1024, 0, 0);
    do_tick();
    chk("R4", "virtual width stride", longint'(stride), 4096);
    chk("R5", "virtual size", longint'(size), 1966080);
    idle(2);

    cur_req = "R5";
    xoff = 8; yoff = 2;
    do_tick();
    chk("R5", "pan offset", longint'(offset), 8224);
    idle(2);

    cur_req = "R6";
    xres = 63;
    do_tick();
    chk("R6", "narrow rejected", longint'(valid), 0);
    chk("R6", "narrow holds offset", longint'(offset), 8224);
    chk("R6", "narrow no strobe", longint'(changed), 0);
    idle(1);
    xres = 640; yres = 63;
    do_tick();
    chk("R6", "short rejected", longint'(valid), 0);
    chk("R6", "short holds height", longint'(height), 480);
    idle(1);
    yres = 64; xres = 64;
    do_tick();
    chk("R6", "64x64 accepted", longint'(valid), 1);
    idle(2);

    cur_req = "R2";
    set_mode(1, 24, 0, 640, 480, 0, 0, 0);
    do_tick();
    chk("R2", "24bpp rejected", longint'(valid), 0);
    chk("R2", "24bpp holds width", longint'(width), 64);
    idle(2);

    cur_req = "R1";
    set_mode(0, 32, 0, 800, 600, 0, 0, 0);
    do_tick();
    chk("R1", "disabled rejected", longint'(valid), 0);
    chk("R1", "disabled no strobe", longint'(changed), 0);
    chk("R1", "disabled holds width", longint'(width), 64);
    idle(2);

    cur_req = "R7";
    set_mode(1, 32, 0, 1024, 1024, 0, 0, 0);
    do_tick();
    chk("R7", "exact fit accepted", longint'(valid), 1);
    chk("R7", "exact fit size", longint'(size), 4194304);
    idle(1);
    yoff = 1;
    do_tick();
    chk("R7", "overrun rejected", longint'(valid), 0);
    chk("R7", "overrun holds offset", longint'(offset), 0);
    idle(2);

    cur_req = "R8";
    set_mode(1, 16, 0, 800, 600, 0, 0, 0);
    idle(4);
    chk("R8", "no tick holds valid", longint'(valid), 0);
    chk("R8", "no tick holds width", longint'(width), 1024);
    chk("R8", "no tick holds fmt", longint'(fmt), 2);
    do_tick();
    chk("R8", "tick applies width", longint'(width), 800);
    idle(2);

    cur_req = "R5";
    set_mode(1, 32, 0, 65535, 65535, 65535, 65535, 65535);
    do_tick();
    chk("R5", "huge pan rejected", longint'(valid), 0);
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule